// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms operand addresses for the indexed addressing forms of a 16-bit processor. For each request it takes a decoded mode, a choice of base register (X, Y, SP or PC), the constant offset field from the instruction stream, an auto-modify step, and the current contents of the X, Y, SP and PC registers and of the 8-bit accumulators A and B. The 16-bit accumulator D is the pair A:B, with A as the high byte. For each request it returns three things. The first is the effective address. The second is a write-back value for the base register, with its enable and its register select. The third is an illegal-mode flag.

The two indirect forms compute a pointer location. The block hands that location out on a pointer-fetch channel. It then takes the 16-bit word that memory returns and reports that word as the final address. Decode, the memory bus and the register file are outside the block. The register and accumulator inputs are captured only in the cycle a request is accepted. Changes to them afterwards do not affect that request.

The request and result sides are valid/ready streams, and the pointer-fetch request is also valid/ready. A request is accepted only while the block is idle. Only one request is in flight at a time. A result stays valid, and every result field stays stable, until the consumer asserts `res_ready`. The pointer request address is held in the same way until `ptr_ready`. A pointer response has no back-pressure. It is taken in the first cycle `ptr_rsp_valid` is high after the pointer request has been handed over. In every other cycle `ptr_rsp_valid` is ignored.

Top module: `idx_ea_gen`

## Requirements
- R1: Mode code 0 adds the low 5 bits of `req_offset`, sign-extended, to the selected base. This gives a reach of −16..+15. The upper offset bits are ignored, and no write-back happens.
- R2: Mode code 1 adds the low 9 bits of `req_offset`, sign-extended, to the base. This gives a reach of −256..+255, with no write-back.
- R3: Mode code 2 adds all 16 bits of `req_offset`, as a signed value, to the base, with no write-back.
- R4: Mode codes 3, 4 and 5 add the zero-extended value of A, of B, or of D = {A,B} to the base. No write-back happens for these modes.
- R5: Mode codes 6 (pre-increment) and 7 (pre-decrement) apply a step of `req_step`+1 (1..8) to the base. The adjusted value is both the address and the write-back value, and `res_wb_en` is 1.
- R6: Mode codes 8 (post-increment) and 9 (post-decrement) report the unmodified base as the address. They write back the base adjusted by `req_step`+1, with `res_wb_en` at 1.
- R7: An auto-modify mode (codes 6..9) with base select 3 (PC) sets `res_illegal`. It reports address 0 and gives `res_wb_en` = 0.
- R8: Mode code 10 puts base + signed 16-bit offset on `ptr_addr`, and mode code 11 puts base + D there. `ptr_valid` and `ptr_addr` are held until `ptr_ready`. After that, the data of the next pointer response becomes `res_ea`, with no write-back.
- R9: After reset, `req_ready` is 1 and `ptr_valid` and `res_valid` are 0. `req_ready` is 1 only when no request is in flight. Result fields hold while `res_valid` is high and `res_ready` is low. Register inputs are sampled only at acceptance.
- R10: Mode codes 12..15 set `res_illegal`, with address 0 and no write-back.
- R11: All sums and differences wrap modulo 2^16.
- R12: `res_wb_sel` repeats the base select of the request (0 X, 1 Y, 2 SP, 3 PC). `res_wb_val` is meaningful only when `res_wb_en` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting |
| req_mode | input | 4 | Addressing mode code |
| req_base | input | 2 | Base select: 0 X, 1 Y, 2 SP, 3 PC |
| req_offset | input | 16 | Constant offset field |
| req_step | input | 3 | Auto-modify step minus one |
| reg_x | input | 16 | X register value |
| reg_y | input | 16 | Y register value |
| reg_sp | input | 16 | Stack pointer value |
| reg_pc | input | 16 | Program counter value |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| ptr_valid | output | 1 | Pointer fetch requested |
| ptr_ready | input | 1 | Pointer fetch accepted |
| ptr_addr | output | 16 | Location of the pointer word |
| ptr_rsp_valid | input | 1 | Pointer word returned |
| ptr_rsp_data | input | 16 | Returned pointer word |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result consumed |
| res_ea | output | 16 | Effective address |
| res_wb_en | output | 1 | Base register write-back enable |
| res_wb_sel | output | 2 | Register to write back |
| res_wb_val | output | 16 | Adjusted base value |
| res_illegal | output | 1 | Mode not allowed |

## Verification
Several properties are checked on every cycle. The handshake rules are checked continuously: no acceptance while busy, results held under back-pressure, and the pointer request held until taken. Every illegal or PC auto-modify result is checked for no write-back. The post-modify address, the pre-modify address/write-back agreement, the B offset and the D-indirect pointer location are also checked on every acceptance. Other behaviour can only be shown by the bench's chosen scenarios. These include the sign handling of each offset width at its extreme values, wraparound at the 64K boundary, the pointer word being substituted after delayed hand-offs, and register changes after acceptance having no effect.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

  localparam int unsigned EA_W    = 16;
  localparam int unsigned ACC_W   = 8;
  localparam int unsigned SHORT_W = 5;
  localparam int unsigned MID_W   = 9;
  localparam int unsigned STEP_W  = 3;

  typedef enum logic [3:0] {
    MODE_OFF_SHORT = 4'd0,
    MODE_OFF_MID   = 4'd1,
    MODE_OFF_WIDE  = 4'd2,
    MODE_ACC_A     = 4'd3,
    MODE_ACC_B     = 4'd4,
    MODE_ACC_D     = 4'd5,
    MODE_PRE_INC   = 4'd6,
    MODE_PRE_DEC   = 4'd7,
    MODE_POST_INC  = 4'd8,
    MODE_POST_DEC  = 4'd9,
    MODE_IND_WIDE  = 4'd10,
    MODE_IND_D     = 4'd11
  } idx_mode_e;

  typedef enum logic [1:0] {
    BASE_X  = 2'd0,
    BASE_Y  = 2'd1,
    BASE_SP = 2'd2,
    BASE_PC = 2'd3
  } base_sel_e;

  typedef enum logic [1:0] {
    SEQ_IDLE     = 2'd0,
    SEQ_PTR_REQ  = 2'd1,
    SEQ_PTR_WAIT = 2'd2,
    SEQ_RESULT   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/idx_base_mux.sv
module idx_base_mux #(
  parameter int unsigned AW   = 16,
  parameter int unsigned NSEL = 4,
  localparam int unsigned SW  = $clog2(NSEL)
) (
  input  logic [SW-1:0]            sel,
  input  logic [NSEL-1:0][AW-1:0]  bank,
  output logic [AW-1:0]            base
);

  // one entry per architectural base register
  assign base = bank[sel];

endmodule

// File: rtl/idx_offset_gen.sv
module idx_offset_gen
  import idx_ea_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned ACC_W   = 8,
  parameter int unsigned SHORT_W = 5,
  parameter int unsigned MID_W   = 9,
  parameter int unsigned STEP_W  = 3
) (
  input  idx_mode_e          mode,
  input  logic [AW-1:0]      offset,
  input  logic [STEP_W-1:0]  step,
  input  logic [ACC_W-1:0]   acc_a,
  input  logic [ACC_W-1:0]   acc_b,
  output logic [AW-1:0]      ea_addend,
  output logic [AW-1:0]      wb_addend,
  output logic               is_auto,
  output logic               is_indirect,
  output logic               bad_mode
);

  localparam int unsigned NCONST = 3;
  localparam int unsigned D_W    = 2 * ACC_W;

  logic [AW-1:0] const_ext [NCONST];
  logic [AW-1:0] a_ext, b_ext, d_ext;
  logic [AW-1:0] step_up, step_dn;

  // sign extension of the three constant widths: short, mid, full
  for (genvar g = 0; g < NCONST; g++) begin : g_const
    localparam int unsigned W = (g == 0) ? SHORT_W : (g == 1) ? MID_W : AW;
    assign const_ext[g] = AW'($signed(offset[W-1:0]));
  end

  // accumulators are unsigned displacements
  assign a_ext = AW'(acc_a);
  assign b_ext = AW'(acc_b);
  assign d_ext = AW'({acc_a, acc_b});

  // step field encodes magnitude minus one, giving 1..2^STEP_W
  assign step_up = AW'(step) + AW'(1);
  assign step_dn = '0 - step_up;

  always_comb begin
    ea_addend   = '0;
    wb_addend   = '0;
    is_auto     = 1'b0;
    is_indirect = 1'b0;
    bad_mode    = 1'b0;
    case (mode)
      MODE_OFF_SHORT: ea_addend = const_ext[0];
      MODE_OFF_MID:   ea_addend = const_ext[1];
      MODE_OFF_WIDE:  ea_addend = const_ext[2];
      MODE_ACC_A:     ea_addend = a_ext;
      MODE_ACC_B:     ea_addend = b_ext;
      MODE_ACC_D:     ea_addend = d_ext;
      MODE_PRE_INC: begin
        ea_addend = step_up;
        wb_addend = step_up;
        is_auto   = 1'b1;
      end
      MODE_PRE_DEC: begin
        ea_addend = step_dn;
        wb_addend = step_dn;
        is_auto   = 1'b1;
      end
      MODE_POST_INC: begin
        wb_addend = step_up;
        is_auto   = 1'b1;
      end
      MODE_POST_DEC: begin
        wb_addend = step_dn;
        is_auto   = 1'b1;
      end
      MODE_IND_WIDE: begin
        ea_addend   = const_ext[2];
        is_indirect = 1'b1;
      end
      MODE_IND_D: begin
        ea_addend   = d_ext;
        is_indirect = 1'b1;
      end
      default: bad_mode = 1'b1;
    endcase
  end

  // D_W must match the address width for the pair to act as a full offset
  logic unused_dw;
  assign unused_dw = (D_W == AW) ? 1'b0 : 1'b1;

endmodule

// File: rtl/idx_addr_calc.sv
module idx_addr_calc
  import idx_ea_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  base_sel_e      sel,
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  ea_addend,
  input  logic [AW-1:0]  wb_addend,
  input  logic           is_auto,
  input  logic           is_indirect,
  input  logic           bad_mode,
  output logic [AW-1:0]  ea,
  output logic [AW-1:0]  wb_val,
  output logic           wb_en,
  output logic           illegal,
  output logic           indirect
);

  logic [AW-1:0] sum_ea;
  logic          pc_modify;

  // auto-modify of the program counter is not a legal combination
  assign pc_modify = is_auto & (sel == BASE_PC);
  assign illegal   = bad_mode | pc_modify;

  // both adders wrap modulo 2^AW
  assign sum_ea = base + ea_addend;
  assign wb_val = base + wb_addend;

  assign ea       = illegal ? '0 : sum_ea;
  assign wb_en    = is_auto & ~illegal;
  assign indirect = is_indirect & ~illegal;

endmodule

// File: rtl/idx_ea_seq.sv
module idx_ea_seq
  import idx_ea_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  base_sel_e      sel,
  input  logic [AW-1:0]  ea_c,
  input  logic [AW-1:0]  wb_val_c,
  input  logic           wb_en_c,
  input  logic           illegal_c,
  input  logic           indirect_c,
  output logic           ptr_valid,
  input  logic           ptr_ready,
  input  logic           ptr_rsp_valid,
  input  logic [AW-1:0]  ptr_rsp_data,
  output logic           res_valid,
  input  logic           res_ready,
  output logic [AW-1:0]  addr_q,
  output logic           wb_en_q,
  output base_sel_e      wb_sel_q,
  output logic [AW-1:0]  wb_val_q,
  output logic           illegal_q
);

  seq_state_e state_q;

  assign req_ready = (state_q == SEQ_IDLE);
  assign ptr_valid = (state_q == SEQ_PTR_REQ);
  assign res_valid = (state_q == SEQ_RESULT);

  // addr_q serves first as pointer location, then as the final address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      addr_q    <= '0;
      wb_en_q   <= 1'b0;
      wb_sel_q  <= BASE_X;
      wb_val_q  <= '0;
      illegal_q <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (req_valid) begin
            addr_q    <= ea_c;
            wb_en_q   <= wb_en_c;
            wb_sel_q  <= sel;
            wb_val_q  <= wb_val_c;
            illegal_q <= illegal_c;
            state_q   <= indirect_c ? SEQ_PTR_REQ : SEQ_RESULT;
          end
        end
        SEQ_PTR_REQ: begin
          if (ptr_ready) state_q <= SEQ_PTR_WAIT;
        end
        SEQ_PTR_WAIT: begin
          if (ptr_rsp_valid) begin
            addr_q  <= ptr_rsp_data;
            state_q <= SEQ_RESULT;
          end
        end
        SEQ_RESULT: begin
          if (res_ready) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
  import idx_ea_pkg::*;
#(
  parameter int unsigned ADDR_W  = EA_W,
  parameter int unsigned ACC_DW  = ACC_W,
  parameter int unsigned SHORT_DW = SHORT_W,
  parameter int unsigned MID_DW  = MID_W,
  parameter int unsigned STEP_DW = STEP_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [3:0]          req_mode,
  input  logic [1:0]          req_base,
  input  logic [ADDR_W-1:0]   req_offset,
  input  logic [STEP_DW-1:0]  req_step,
  input  logic [ADDR_W-1:0]   reg_x,
  input  logic [ADDR_W-1:0]   reg_y,
  input  logic [ADDR_W-1:0]   reg_sp,
  input  logic [ADDR_W-1:0]   reg_pc,
  input  logic [ACC_DW-1:0]   acc_a,
  input  logic [ACC_DW-1:0]   acc_b,
  output logic                ptr_valid,
  input  logic                ptr_ready,
  output logic [ADDR_W-1:0]   ptr_addr,
  input  logic                ptr_rsp_valid,
  input  logic [ADDR_W-1:0]   ptr_rsp_data,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [ADDR_W-1:0]   res_ea,
  output logic                res_wb_en,
  output logic [1:0]          res_wb_sel,
  output logic [ADDR_W-1:0]   res_wb_val,
  output logic                res_illegal
);

  localparam int unsigned NBASE = 4;

  logic [NBASE-1:0][ADDR_W-1:0] bank;
  logic [ADDR_W-1:0] base, ea_addend, wb_addend;
  logic [ADDR_W-1:0] ea_c, wb_val_c, addr_q;
  logic is_auto, is_indirect, bad_mode;
  logic wb_en_c, illegal_c, indirect_c;
  base_sel_e sel, wb_sel_q;

  assign sel  = base_sel_e'(req_base);
  assign bank = {reg_pc, reg_sp, reg_y, reg_x};

  idx_base_mux #(.AW(ADDR_W), .NSEL(NBASE)) u_base (
    .sel  (req_base),
    .bank (bank),
    .base (base)
  );

  idx_offset_gen #(
    .AW(ADDR_W), .ACC_W(ACC_DW), .SHORT_W(SHORT_DW),
    .MID_W(MID_DW), .STEP_W(STEP_DW)
  ) u_off (
    .mode        (idx_mode_e'(req_mode)),
    .offset      (req_offset),
    .step        (req_step),
    .acc_a       (acc_a),
    .acc_b       (acc_b),
    .ea_addend   (ea_addend),
    .wb_addend   (wb_addend),
    .is_auto     (is_auto),
    .is_indirect (is_indirect),
    .bad_mode    (bad_mode)
  );

  idx_addr_calc #(.AW(ADDR_W)) u_calc (
    .sel         (sel),
    .base        (base),
    .ea_addend   (ea_addend),
    .wb_addend   (wb_addend),
    .is_auto     (is_auto),
    .is_indirect (is_indirect),
    .bad_mode    (bad_mode),
    .ea          (ea_c),
    .wb_val      (wb_val_c),
    .wb_en       (wb_en_c),
    .illegal     (illegal_c),
    .indirect    (indirect_c)
  );

  idx_ea_seq #(.AW(ADDR_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .sel           (sel),
    .ea_c          (ea_c),
    .wb_val_c      (wb_val_c),
    .wb_en_c       (wb_en_c),
    .illegal_c     (illegal_c),
    .indirect_c    (indirect_c),
    .ptr_valid     (ptr_valid),
    .ptr_ready     (ptr_ready),
    .ptr_rsp_valid (ptr_rsp_valid),
    .ptr_rsp_data  (ptr_rsp_data),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .addr_q        (addr_q),
    .wb_en_q       (res_wb_en),
    .wb_sel_q      (wb_sel_q),
    .wb_val_q      (res_wb_val),
    .illegal_q     (res_illegal)
  );

  assign ptr_addr   = addr_q;
  assign res_ea     = addr_q;
  assign res_wb_sel = wb_sel_q;

endmodule

// File: rtl/idx_ea_chk.sv
module idx_ea_chk #(
  parameter int unsigned AW    = idx_ea_pkg::EA_W,
  parameter int unsigned ACC_W = idx_ea_pkg::ACC_W
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic [3:0]     req_mode,
  input logic [1:0]     req_base,
  input logic [AW-1:0]  reg_x,
  input logic [AW-1:0]  reg_y,
  input logic [AW-1:0]  reg_sp,
  input logic [AW-1:0]  reg_pc,
  input logic [ACC_W-1:0] acc_a,
  input logic [ACC_W-1:0] acc_b,
  input logic           ptr_valid,
  input logic           ptr_ready,
  input logic [AW-1:0]  ptr_addr,
  input logic           res_valid,
  input logic           res_ready,
  input logic [AW-1:0]  res_ea,
  input logic           res_wb_en,
  input logic [1:0]     res_wb_sel,
  input logic [AW-1:0]  res_wb_val,
  input logic           res_illegal
);

  logic [AW-1:0] chk_base;
  logic          accept;

  always_comb begin
    case (req_base)
      2'd0:    chk_base = reg_x;
      2'd1:    chk_base = reg_y;
      2'd2:    chk_base = reg_sp;
      default: chk_base = reg_pc;
    endcase
  end

  assign accept = req_valid && req_ready;

  p_busy_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || ptr_valid) |-> !req_ready);

  p_res_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_ea) && $stable(res_wb_en)
      && $stable(res_wb_sel) && $stable(res_wb_val) && $stable(res_illegal)));

  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_valid && !ptr_ready) |=> (ptr_valid && $stable(ptr_addr)));

  p_one_channel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ptr_valid && res_valid));

  p_pc_no_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_wb_sel == 2'd3) |-> !res_wb_en);

  p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_illegal) |-> (!res_wb_en && res_ea == '0));

  p_post_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_mode == 4'd8 || req_mode == 4'd9) && req_base != 2'd3)
      |=> (res_valid && res_wb_en && res_ea == $past(chk_base)));

  p_pre_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_mode == 4'd6 || req_mode == 4'd7) && req_base != 2'd3)
      |=> (res_valid && res_wb_en && res_ea == res_wb_val));

  p_acc_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode == 4'd4)
      |=> (res_valid && !res_wb_en && res_ea == $past(chk_base) + AW'($past(acc_b))));

  p_ind_d_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode == 4'd11)
      |=> (ptr_valid && ptr_addr == $past(chk_base) + AW'($past({acc_a, acc_b}))));

endmodule

bind idx_ea_gen idx_ea_chk u_chk (.*);

// File: tb/idx_ea_gen_tb_top.sv
module idx_ea_gen_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_PERIOD_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [3:0] req_mode = '0;
  logic [1:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [2:0] req_step = '0;
  logic [15:0] reg_x = 16'h1000, reg_y = 16'h2000, reg_sp = 16'h3FF0, reg_pc = 16'hE000;
  logic [7:0] acc_a = 8'h12, acc_b = 8'h34;
  logic ptr_valid;
  logic ptr_ready = 1'b0;
  logic [15:0] ptr_addr;
  logic ptr_rsp_valid = 1'b0;
  logic [15:0] ptr_rsp_data = '0;
  logic res_valid;
  logic res_ready = 1'b0;
  logic [15:0] res_ea;
  logic res_wb_en;
  logic [1:0] res_wb_sel;
  logic [15:0] res_wb_val;
  logic res_illegal;

  always #(CLK_PERIOD_NS / 2) clk = ~clk;

  idx_ea_gen dut_i (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state: 0 idle, 1 pointer request, 2 pointer wait, 3 result
  int m_phase = 0;
  int m_ea = 0, m_wb_en = 0, m_wb_val = 0, m_sel = 0, m_ill = 0;
  string m_tag = "R9";

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", m_tag, what, act, exp);
    end
  endtask

  function automatic int sx(int v, int w);
    int m = v & ((1 << w) - 1);
    if (m >= (1 << (w - 1))) m -= (1 << w);
    return m;
  endfunction

  function automatic void ref_calc(input int mode, input int sel, input int off, input int step,
                                   output int ea, output int wen, output int wval,
                                   output int ill, output int ind);
    int base, d, s;
    base = (sel == 0) ? int'(reg_x) : (sel == 1) ? int'(reg_y) :
           (sel == 2) ? int'(reg_sp) : int'(reg_pc);
    d = int'(acc_a) * 256 + int'(acc_b);
    s = step + 1;
    ea = 0; wen = 0; wval = 0; ill = 0; ind = 0;
    case (mode)
      0: ea = (base + sx(off, 5)) & 'hFFFF;
      1: ea = (base + sx(off, 9)) & 'hFFFF;
      2: ea = (base + sx(off, 16)) & 'hFFFF;
      3: ea = (base + int'(acc_a)) & 'hFFFF;
      4: ea = (base + int'(acc_b)) & 'hFFFF;
      5: ea = (base + d) & 'hFFFF;
      6, 7, 8, 9: begin
        if (sel == 3) ill = 1;
        else begin
          wval = ((mode == 6 || mode == 8) ? base + s : base - s) & 'hFFFF;
          wen = 1;
          ea = (mode <= 7) ? wval : base;
        end
      end
      10: begin ea = (base + sx(off, 16)) & 'hFFFF; ind = 1; end
      11: begin ea = (base + d) & 'hFFFF; ind = 1; end
      default: ill = 1;
    endcase
  endfunction

  task automatic compare();
    chk("req_ready", int'(req_ready), int'(m_phase == 0));
    chk("ptr_valid", int'(ptr_valid), int'(m_phase == 1));
    chk("res_valid", int'(res_valid), int'(m_phase == 3));
    if (m_phase == 1) chk("ptr_addr", int'(ptr_addr), m_ea);
    if (m_phase == 3) begin
      chk("res_ea", int'(res_ea), m_ea);
      chk("res_wb_en", int'(res_wb_en), m_wb_en);
      chk("res_illegal", int'(res_illegal), m_ill);
      chk("res_wb_sel", int'(res_wb_sel), m_sel);
      if (m_wb_en != 0) chk("res_wb_val", int'(res_wb_val), m_wb_val);
    end
  endtask

  // advance the model with the inputs now driven, cross one edge, compare
  task automatic tick();
    int nxt = m_phase;
    int ind;
    case (m_phase)
      0: if (req_valid) begin
           ref_calc(int'(req_mode), int'(req_base), int'(req_offset), int'(req_step),
                    m_ea, m_wb_en, m_wb_val, m_ill, ind);
           m_sel = int'(req_base);
           nxt = (ind != 0) ? 1 : 3;
         end
      1: if (ptr_ready) nxt = 2;
      2: if (ptr_rsp_valid) begin m_ea = int'(ptr_rsp_data); nxt = 3; end
      default: if (res_ready) nxt = 0;
    endcase
    @(posedge clk);
    m_phase = nxt;
    @(negedge clk);
    compare();
  endtask

  task automatic issue(string tag, int mode, int sel, int off, int step,
                       int ptr_delay, int rsp_gap, int rsp_word, int res_delay, bit poke);
    m_tag = tag;
    req_mode = 4'(mode);
    req_base = 2'(sel);
    req_offset = 16'(off);
    req_step = 3'(step);
    req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    // registers move after acceptance; the result must not follow (R9)
    reg_x ^= 16'h5A5A; reg_y ^= 16'h0F0F; reg_sp ^= 16'h3333; reg_pc ^= 16'h0101;
    acc_a ^= 8'hFF; acc_b ^= 8'h81;
    if (m_phase == 1) begin
      repeat (ptr_delay) tick();
      ptr_ready = 1'b1;
      tick();
      ptr_ready = 1'b0;
      repeat (rsp_gap) tick();
      ptr_rsp_data = 16'(rsp_word);
      ptr_rsp_valid = 1'b1;
      tick();
      ptr_rsp_valid = 1'b0;
    end
    if (poke) begin
      req_valid = 1'b1;
      req_mode = 4'd0;
    end
    repeat (res_delay) tick();
    req_valid = 1'b0;
    res_ready = 1'b1;
    tick();
    res_ready = 1'b0;
    reg_x ^= 16'h5A5A; reg_y ^= 16'h0F0F; reg_sp ^= 16'h3333; reg_pc ^= 16'h0101;
    acc_a ^= 8'hFF; acc_b ^= 8'h81;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_tag = "R9";
    compare();                                           // R9 reset state
    issue("R1", 0, 0, 'h000F, 0, 0, 0, 0, 0, 0);          // +15
    issue("R1", 0, 1, 'h0010, 0, 0, 0, 0, 0, 0);          // -16
    issue("R1", 0, 2, 'hFFF6, 0, 0, 0, 0, 1, 0);          // upper bits ignored, -10
    issue("R2", 1, 2, 'h00FF, 0, 0, 0, 0, 0, 0);          // +255
    issue("R2", 1, 3, 'h0100, 0, 0, 0, 0, 0, 0);          // -256
    issue("R3", 2, 1, 'hB000, 0, 0, 0, 0, 0, 0);
    reg_x = 16'hF000;
    issue("R11", 2, 0, 'h2000, 0, 0, 0, 0, 0, 0);         // wraps to 0x1000
    reg_x = 16'h1000;
    issue("R4", 3, 0, 0, 0, 0, 0, 0, 0, 0);
    issue("R4", 4, 3, 0, 0, 0, 0, 0, 0, 0);
    acc_a = 8'hFF; acc_b = 8'h80;
    issue("R4", 5, 1, 0, 0, 0, 0, 0, 0, 0);               // D unsigned, wraps
    acc_a = 8'h12; acc_b = 8'h34;
    issue("R5", 6, 0, 0, 7, 0, 0, 0, 0, 0);               // +8
    issue("R5", 7, 2, 0, 0, 0, 0, 0, 0, 0);               // -1
    issue("R6", 8, 1, 0, 3, 0, 0, 0, 2, 0);
    reg_x = 16'h0002;
    issue("R11", 9, 0, 0, 7, 0, 0, 0, 0, 0);              // wb 0xFFFA
    reg_x = 16'h1000;
    issue("R7", 6, 3, 0, 2, 0, 0, 0, 0, 0);
    issue("R7", 9, 3, 0, 0, 0, 0, 0, 0, 0);
    issue("R8", 10, 0, 'h0004, 0, 2, 1, 'h9800, 0, 0);
    issue("R8", 11, 3, 0, 0, 0, 0, 'h1234, 1, 0);
    issue("R10", 13, 1, 0, 0, 0, 0, 0, 0, 0);
    issue("R10", 15, 0, 0, 0, 0, 0, 0, 0, 0);
    issue("R9", 1, 0, 'h0003, 0, 0, 0, 0, 3, 1);          // held, busy request ignored
    issue("R12", 2, 2, 'h0010, 0, 0, 0, 0, 0, 0);
    m_tag = "R9";
    tick();                                               // idle again
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

endmodule